// File: doc/BRIEF.md
# Half-Bridge Gate Command Sequencer

This block sits between a PWM source and the two gate drivers of a half-bridge. It takes a request for the upper switch and a request for the lower switch and returns one gate command for each. Each request first passes a digital glitch filter. A dead-time counter then keeps a gap between one command going low and the other going high. A separate output gate makes sure the two commands are never high together.

The block also applies the restart rules that follow a supply dropout. If the low-side supply is lost, both commands go low. When it returns, the lower command takes the level of its filtered request again. If the upper supply is lost, only the upper command goes low. The upper command is then disarmed and comes back only after a new rising edge on its request.

All timing is counted in clock cycles. The counts come from the clock period and from a mode parameter that picks timing for IGBT or MOSFET switches. Each count is rounded up, so no filter window or gap is ever shorter than its nominal time.

Top module: `hbg_sequencer`

## Requirements
- R1: While reset is held and right after it, both commands are low. The upper side starts disarmed, so an upper request held high through reset never drives the upper command.
- R2: A request level must stay stable for at least its filter window before the block sees it. The window is ceil(ns / CLK_PERIOD_NS) cycles. In MOSFET mode the nominal times are 100 ns for the upper input and 150 ns for the lower input. In IGBT mode both inputs use 190 ns. With the defaults (MOSFET mode, 10 ns clock) the windows are 10 and 15 cycles.
- R3: A request change that survives the filter reaches its command (filter window + 1) cycles after the request changes, provided nothing else holds the command back.
- R4: After one command falls, the other command may rise no earlier than DT cycles later. DT is ceil(ns / CLK_PERIOD_NS) of 75 ns in MOSFET mode or 380 ns in IGBT mode, which gives 8 cycles with the defaults. A side that turns back on after its own turn-off does not wait.
- R5: The two commands are never high in the same cycle.
- R6: When both filtered requests are high, a command that is already high stays high and the other stays low. If neither command was high, both stay low.
- R7: While shutdown is high, both commands are low from the next cycle onward. Once shutdown is released, the commands follow their requests again.
- R8: While the low-side supply-good input is low, both commands are low from the next cycle. When it returns high, the lower command takes its filtered request level on the next cycle.
- R9: While the high-side supply-good input is low, the upper command is low from the next cycle. The lower command keeps following its own request.
- R10: After a high-side supply dropout, the upper command stays low, even if its request is still high, until the filtered upper request rises again while the high-side supply is good.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| hs_req_i | input | 1 | Upper switch PWM request |
| ls_req_i | input | 1 | Lower switch PWM request |
| shut_i | input | 1 | Global shutdown, active high |
| ls_pwr_ok_i | input | 1 | Low-side supply good |
| hs_pwr_ok_i | input | 1 | High-side supply good |
| hs_gate_o | output | 1 | Upper gate command |
| ls_gate_o | output | 1 | Lower gate command |

## Verification
A request change shows up on its command exactly (filter window + 1) cycles later, because the filter register and the output register each add one stage. A turn-on that waits for dead time lands DT cycles after the other command fell. Shutdown and supply-good changes act one cycle after they are driven. The bench computes every expected value from these counts and queues it against an absolute cycle number. It then compares the expected value on the falling edge of that cycle, and in most cases also checks the cycle just before, so that an early change is caught as well as a late one.

// File: rtl/hbg_pkg.sv
package hbg_pkg;

    localparam int MOS_HS_FILT_NS = 100;
    localparam int MOS_LS_FILT_NS = 150;
    localparam int IGBT_FILT_NS   = 190;
    localparam int MOS_DEAD_NS    = 75;
    localparam int IGBT_DEAD_NS   = 380;

    typedef enum logic [1:0] {
        SIDE_NONE = 2'd0,
        SIDE_HS   = 2'd1,
        SIDE_LS   = 2'd2
    } side_e;

    // round a nanosecond figure up to whole clock cycles, minimum one
    function automatic int ns_to_cyc(input int ns, input int period_ns);
        int c;
        c = (ns + period_ns - 1) / period_ns;
        return (c < 1) ? 1 : c;
    endfunction

    function automatic int hs_filt_cyc(input bit igbt, input int period_ns);
        return ns_to_cyc(igbt ? IGBT_FILT_NS : MOS_HS_FILT_NS, period_ns);
    endfunction

    function automatic int ls_filt_cyc(input bit igbt, input int period_ns);
        return ns_to_cyc(igbt ? IGBT_FILT_NS : MOS_LS_FILT_NS, period_ns);
    endfunction

    function automatic int dead_cyc(input bit igbt, input int period_ns);
        return ns_to_cyc(igbt ? IGBT_DEAD_NS : MOS_DEAD_NS, period_ns);
    endfunction

endpackage

// File: rtl/hbg_glitch_filter.sv
module hbg_glitch_filter #(
    parameter int   FILT_CYC = 10,
    parameter logic INIT_VAL = 1'b0
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic raw_i,
    output logic filt_o
);
    localparam int CW = $clog2(FILT_CYC + 1);
    localparam logic [CW-1:0] LAST = CW'(FILT_CYC - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          val;
    } filt_st_t;

    filt_st_t st_d, st_q;

    // the output flips only after FILT_CYC consecutive disagreeing samples
    always_comb begin
        st_d = st_q;
        if (raw_i != st_q.val) begin
            if (st_q.cnt == LAST) begin
                st_d.val = raw_i;
                st_d.cnt = '0;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end else begin
            st_d.cnt = '0;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q.cnt <= '0;
            st_q.val <= INIT_VAL;
        end else begin
            st_q <= st_d;
        end
    end

    assign filt_o = st_q.val;
endmodule

// File: rtl/hbg_arm_tracker.sv
module hbg_arm_tracker (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic filt_i,
    input  logic pwr_ok_i,
    output logic arm_o
);
    typedef struct packed {
        logic prev;
        logic armed;
    } arm_st_t;

    arm_st_t st_d, st_q;
    logic    rise;

    always_comb begin
        rise        = filt_i & ~st_q.prev;
        st_d.prev   = filt_i;
        st_d.armed  = pwr_ok_i & (st_q.armed | rise);
        arm_o       = pwr_ok_i & (st_q.armed | rise);
    end

    // prev starts high so a request held through reset is not taken as an edge
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q.prev  <= 1'b1;
            st_q.armed <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/hbg_deadband_core.sv
module hbg_deadband_core
    import hbg_pkg::*;
#(
    parameter int DEAD_CYC = 8
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic want_hs_i,
    input  logic want_ls_i,
    output logic hs_o,
    output logic ls_o
);
    localparam int GW = $clog2(DEAD_CYC + 1);
    localparam logic [GW-1:0] GAP_DONE = GW'(DEAD_CYC - 1);

    typedef struct packed {
        logic          hs;
        logic          ls;
        logic [GW-1:0] gap;
        side_e         last;
    } core_st_t;

    core_st_t st_d, st_q;
    logic     hs_may, ls_may;

    always_comb begin
        st_d   = st_q;
        hs_may = (st_q.last != SIDE_LS) || (st_q.gap >= GAP_DONE);
        ls_may = (st_q.last != SIDE_HS) || (st_q.gap >= GAP_DONE);

        st_d.hs = 1'b0;
        st_d.ls = 1'b0;
        if (st_q.hs) begin
            st_d.hs = want_hs_i;
        end else if (st_q.ls) begin
            st_d.ls = want_ls_i;
        end else if (want_hs_i && !want_ls_i && hs_may) begin
            st_d.hs = 1'b1;
        end else if (want_ls_i && !want_hs_i && ls_may) begin
            st_d.ls = 1'b1;
        end

        if (st_q.hs || st_q.ls) begin
            st_d.gap = '0;
        end else if (st_q.gap != GAP_DONE) begin
            st_d.gap = st_q.gap + 1'b1;
        end

        if (st_q.hs) begin
            st_d.last = SIDE_HS;
        end else if (st_q.ls) begin
            st_d.last = SIDE_LS;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q.hs   <= 1'b0;
            st_q.ls   <= 1'b0;
            st_q.gap  <= GAP_DONE;
            st_q.last <= SIDE_NONE;
        end else begin
            st_q <= st_d;
        end
    end

    assign hs_o = st_q.hs;
    assign ls_o = st_q.ls;
endmodule

// File: rtl/hbg_sequencer.sv
module hbg_sequencer
    import hbg_pkg::*;
#(
    parameter int CLK_PERIOD_NS = 10,
    parameter bit IGBT_MODE     = 1'b0
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic hs_req_i,
    input  logic ls_req_i,
    input  logic shut_i,
    input  logic ls_pwr_ok_i,
    input  logic hs_pwr_ok_i,
    output logic hs_gate_o,
    output logic ls_gate_o
);
    localparam int HS_FILT  = hs_filt_cyc(IGBT_MODE, CLK_PERIOD_NS);
    localparam int LS_FILT  = ls_filt_cyc(IGBT_MODE, CLK_PERIOD_NS);
    localparam int DEAD_CYC = dead_cyc(IGBT_MODE, CLK_PERIOD_NS);

    logic hs_filt, ls_filt, hs_arm;
    logic want_hs, want_ls;
    logic core_hs, core_ls;

    hbg_glitch_filter #(.FILT_CYC(HS_FILT), .INIT_VAL(1'b1)) hs_filt_i (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .raw_i  (hs_req_i),
        .filt_o (hs_filt)
    );

    hbg_glitch_filter #(.FILT_CYC(LS_FILT), .INIT_VAL(1'b0)) ls_filt_i (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .raw_i  (ls_req_i),
        .filt_o (ls_filt)
    );

    hbg_arm_tracker arm_i (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .filt_i   (hs_filt),
        .pwr_ok_i (hs_pwr_ok_i),
        .arm_o    (hs_arm)
    );

    always_comb begin
        want_ls = ls_filt & ls_pwr_ok_i & ~shut_i;
        want_hs = hs_filt & hs_arm & ls_pwr_ok_i & ~shut_i;
    end

    hbg_deadband_core #(.DEAD_CYC(DEAD_CYC)) core_i (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .want_hs_i (want_hs),
        .want_ls_i (want_ls),
        .hs_o      (core_hs),
        .ls_o      (core_ls)
    );

    // last-stage interlock, independent of the dead-time counter
    assign hs_gate_o = core_hs & ~core_ls;
    assign ls_gate_o = core_ls & ~core_hs;
endmodule

// File: rtl/hbg_sequencer_chk.sv
module hbg_sequencer_chk
    import hbg_pkg::*;
#(
    parameter int CLK_PERIOD_NS = 10,
    parameter bit IGBT_MODE     = 1'b0
) (
    input logic clk_i,
    input logic rst_ni,
    input logic shut_i,
    input logic ls_pwr_ok_i,
    input logic hs_pwr_ok_i,
    input logic hs_gate_o,
    input logic ls_gate_o
);
    localparam int DEAD = dead_cyc(IGBT_MODE, CLK_PERIOD_NS);

    int hs_gap_q, ls_gap_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            hs_gap_q <= DEAD;
            ls_gap_q <= DEAD;
        end else begin
            hs_gap_q <= hs_gate_o ? 0 : ((hs_gap_q < DEAD) ? hs_gap_q + 1 : hs_gap_q);
            ls_gap_q <= ls_gate_o ? 0 : ((ls_gap_q < DEAD) ? ls_gap_q + 1 : ls_gap_q);
        end
    end

    AST_NEVER_BOTH_ON: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(hs_gate_o && ls_gate_o)); // R5
    AST_SHUT_FORCES_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
        shut_i |=> (!hs_gate_o && !ls_gate_o)); // R7
    AST_LS_PWR_FORCES_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !ls_pwr_ok_i |=> (!hs_gate_o && !ls_gate_o)); // R8
    AST_HS_PWR_FORCES_HS_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !hs_pwr_ok_i |=> !hs_gate_o); // R9
    AST_HS_DEAD_GAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(hs_gate_o) |-> (ls_gap_q >= DEAD)); // R4
    AST_LS_DEAD_GAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(ls_gate_o) |-> (hs_gap_q >= DEAD)); // R4
endmodule

bind hbg_sequencer hbg_sequencer_chk #(
    .CLK_PERIOD_NS (CLK_PERIOD_NS),
    .IGBT_MODE     (IGBT_MODE)
) chk_i (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .shut_i      (shut_i),
    .ls_pwr_ok_i (ls_pwr_ok_i),
    .hs_pwr_ok_i (hs_pwr_ok_i),
    .hs_gate_o   (hs_gate_o),
    .ls_gate_o   (ls_gate_o)
);

// File: tb/hbg_sequencer_tb_top.sv
module hbg_sequencer_tb_top;
    localparam int PER = 10;
    localparam int HF  = (100 + PER - 1) / PER;  // R2 upper window
    localparam int LF  = (150 + PER - 1) / PER;  // R2 lower window
    localparam int DT  = (75 + PER - 1) / PER;   // R4 gap

    typedef struct {
        int    cyc;
        logic  h;
        logic  l;
        string tag;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic hs_req = 1'b0, ls_req = 1'b0, shut = 1'b0;
    logic ls_ok = 1'b1, hs_ok = 1'b1;
    logic hs_gate, ls_gate;

    int   cyc = 0;
    int   n_chk = 0;
    int   n_bad = 0;
    bit   done = 1'b0;
    exp_t q[$];

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    hbg_sequencer #(.CLK_PERIOD_NS(PER), .IGBT_MODE(1'b0)) dut_i (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .hs_req_i    (hs_req),
        .ls_req_i    (ls_req),
        .shut_i      (shut),
        .ls_pwr_ok_i (ls_ok),
        .hs_pwr_ok_i (hs_ok),
        .hs_gate_o   (hs_gate),
        .ls_gate_o   (ls_gate)
    );

    // monitor: pop expectations due in this cycle and compare
    always @(negedge clk) begin
        while (q.size() > 0 && q[0].cyc <= cyc) begin
            exp_t e;
            e = q.pop_front();
            n_chk++;
            if (e.cyc != cyc || hs_gate !== e.h || ls_gate !== e.l) begin
                n_bad++;
                $display("FAIL %s cyc=%0d/%0d actual hs=%b ls=%b expected hs=%b ls=%b",
                         e.tag, cyc, e.cyc, hs_gate, ls_gate, e.h, e.l);
            end
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    task automatic expect_in(input int d, input logic h, input logic l, input string tag);
        exp_t e;
        e.cyc = cyc + d;
        e.h   = h;
        e.l   = l;
        e.tag = tag;
        q.push_back(e);
    endtask

    initial begin
        // R1: upper request held high through reset must not drive
        hs_req = 1'b1;
        tick(5);
        rst_n = 1'b1;
        expect_in(1, 0, 0, "R1 reset state");
        expect_in(30, 0, 0, "R1 held request no edge");
        tick(31);
        hs_req = 1'b0;
        tick(30);

        // R3: lower turn-on latency
        ls_req = 1'b1;
        expect_in(LF, 0, 0, "R3 lower not yet");
        expect_in(LF + 1, 0, 1, "R3 lower on");
        tick(LF + 5);

        // R4: hand-over lower to upper with dead time
        ls_req = 1'b0;
        hs_req = 1'b1;
        expect_in(LF, 0, 1, "R4 lower still on");
        expect_in(LF + 1, 0, 0, "R4 lower off");
        expect_in(LF + DT, 0, 0, "R4 gap held");
        expect_in(LF + DT + 1, 1, 0, "R4 upper on after gap");
        tick(LF + DT + 6);

        // R6: upper on, lower request arrives -> upper kept
        ls_req = 1'b1;
        expect_in(LF + 5, 1, 0, "R6 keep upper");
        expect_in(40, 1, 0, "R6 keep upper late");
        tick(41);
        hs_req = 1'b0;
        expect_in(HF, 1, 0, "R4 upper still on");
        expect_in(HF + 1, 0, 0, "R4 upper off");
        expect_in(HF + DT, 0, 0, "R4 gap held rev");
        expect_in(HF + DT + 1, 0, 1, "R4 lower on after gap");
        tick(HF + DT + 6);

        // R2: short pulses are dropped
        ls_req = 1'b0;
        expect_in(LF, 0, 1, "R3 lower off pending");
        expect_in(LF + 1, 0, 0, "R3 lower off");
        tick(30);
        ls_req = 1'b1;
        expect_in(LF + 1, 0, 0, "R2 short lower pulse");
        expect_in(30, 0, 0, "R2 short lower pulse late");
        tick(LF - 1);
        ls_req = 1'b0;
        tick(40);
        hs_req = 1'b1;
        expect_in(HF + 1, 0, 0, "R2 short upper pulse");
        expect_in(25, 0, 0, "R2 short upper pulse late");
        tick(HF - 1);
        hs_req = 1'b0;
        tick(30);

        // R6: both filtered requests rise together from idle -> both off
        ls_req = 1'b1;
        tick(LF - HF);
        hs_req = 1'b1;
        expect_in(HF + 5, 0, 0, "R6 both off");
        expect_in(40, 0, 0, "R6 both off late");
        tick(41);
        ls_req = 1'b0;
        expect_in(LF, 0, 0, "R6 upper waits");
        expect_in(LF + 1, 1, 0, "R6 upper takes over");
        tick(LF + 6);

        // R7: shutdown
        shut = 1'b1;
        expect_in(1, 0, 0, "R7 shutdown low");
        expect_in(20, 0, 0, "R7 shutdown held");
        tick(25);
        shut = 1'b0;
        expect_in(1, 1, 0, "R7 release follows");
        tick(10);

        // R9 / R10: high-side supply dropout
        hs_ok = 1'b0;
        expect_in(1, 0, 0, "R9 upper off");
        tick(5);
        ls_req = 1'b1;
        expect_in(LF + 1, 0, 1, "R9 lower follows");
        tick(LF + 5);
        ls_req = 1'b0;
        expect_in(LF + 1, 0, 0, "R9 lower off");
        tick(30);
        hs_ok = 1'b1;
        expect_in(5, 0, 0, "R10 no rearm early");
        expect_in(30, 0, 0, "R10 no rearm late");
        tick(31);
        hs_req = 1'b0;
        tick(20);
        hs_req = 1'b1;
        expect_in(HF, 0, 0, "R10 edge pending");
        expect_in(HF + 1, 1, 0, "R10 fresh edge rearms");
        tick(20);

        // R8: low-side supply dropout
        hs_req = 1'b0;
        expect_in(HF + 1, 0, 0, "R8 upper off");
        tick(30);
        ls_req = 1'b1;
        expect_in(LF + 1, 0, 1, "R8 lower on");
        tick(LF + 5);
        ls_ok = 1'b0;
        expect_in(1, 0, 0, "R8 forced low");
        expect_in(10, 0, 0, "R8 forced low held");
        tick(10);
        ls_ok = 1'b1;
        expect_in(1, 0, 1, "R8 lower restores level");
        tick(10);

        while (q.size() > 0) tick(1);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end
endmodule